// File: doc/BRIEF.md
# Radio Power-State and Front-End Switch Controller

This block turns a power-enable pin and a two-bit power-mode field into one of four device power states. For each state it registers the enables for the reference oscillator, the serial port, both VCOs, the transmitter and the receiver. It also drives the control lines to an external RF front end. These are an active-low front-end power switch, two active-low per-band PA power switches and a band-select line. The PA switches depend on the power state, the transmit/receive pin, the PA-enable pin and the band bit together. A calibration-busy flag can force the front end off, but only while the receiver is active.

The controller has four states. `ST_SLEEP` is held while power-enable is low. `ST_STANDBY` runs the oscillator and the serial port. `ST_IDLE` also runs the VCOs. `ST_ACTIVE` also runs the transmitter or the receiver. The transitions are:
- `T_POWER_DOWN` goes from any state to sleep when power-enable is low.
- `T_WAKE` goes from sleep to standby when power-enable is high. It takes one cycle and ignores the mode field, because the register file is reloading its defaults in that cycle.
- `T_SELECT` moves among standby, idle and active, following the mode field.

Top module: `pmfe_ctrl`

## Requirements
- R1: While `rst_n` is low, the controller is in sleep. In sleep `pwr_state` = 0, every enable is 0, `cal_act` and `reload_pulse` are 0, `fe_off`, `pa_off_a` and `pa_off_b` are 1, and `band_out` is 0.
- R2: If `pwr_en` is low, the controller is in sleep one cycle later, whatever state it was in. Every output then takes its sleep value.
- R3: If `pwr_en` is high while the controller is in sleep, the next state is standby and `reload_pulse` is high for exactly that one cycle, whatever `mode_fld` holds. After that the state follows `mode_fld`.
- R4: When awake, `mode_fld` 00 gives standby (`pwr_state` = 1), 01 gives idle (2), and 10 or 11 gives active (3). `osc_on` and `ser_on` are 1 in every awake state. `vco_on` is 1 in idle and active.
- R5: In active, `tx_on` is 1 when `tx_sel` is 1 and `rx_on` is 1 when `tx_sel` is 0. Outside active, both are 0.
- R6: A PA is powered only in active with `tx_sel` = 1 and `pa_en` = 1. `pa_off_a` is 0 only when in addition `band_a` = 1, and `pa_off_b` is 0 only when in addition `band_a` = 0. Otherwise both are 1.
- R7: `band_out` equals `band_a` in every awake state and is 0 in sleep.
- R8: `fe_off` is 0 only in active with no calibration running. Otherwise it is 1.
- R9: A calibration runs when `cal_busy` is 1 in active with `tx_sel` = 0. While it runs, `cal_act` = 1, `fe_off` = 1 and `rx_on` stays 1. In any other state or mode, `cal_busy` has no effect on any output.
- R10: All outputs are registered. They reflect the inputs present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power-enable pin; low means sleep |
| mode_fld | input | 2 | Power-mode register field |
| tx_sel | input | 1 | Transmit (1) / receive (0) pin |
| pa_en | input | 1 | PA enable pin |
| band_a | input | 1 | Band bit: 1 = band A, 0 = band B |
| cal_busy | input | 1 | Receive DC-offset calibration in progress |
| pwr_state | output | 2 | 0 sleep, 1 standby, 2 idle, 3 active |
| osc_on | output | 1 | Reference oscillator enable |
| ser_on | output | 1 | Serial port enable |
| vco_on | output | 1 | RF and IF VCO enable |
| tx_on | output | 1 | Transmit chain enable |
| rx_on | output | 1 | Receive chain enable |
| fe_off | output | 1 | Front-end switch, active low (1 = front end off) |
| pa_off_a | output | 1 | Band-A PA switch, active low |
| pa_off_b | output | 1 | Band-B PA switch, active low |
| band_out | output | 1 | Band select to front end |
| cal_act | output | 1 | Calibration is running and holding the front end off |
| reload_pulse | output | 1 | One-cycle pulse on leaving sleep |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold a defined 0 or 1 at every rising edge, so no metastable or X input reaches the decode. The bench changes inputs only on falling edges and drives every input to a known level before reset is released. The assertions also assume that `cal_busy` comes from an engine that may raise it in any state. The bench therefore deliberately raises it in idle and in transmit-active, as well as in receive-active.

// File: rtl/pmfe_pkg.sv
package pmfe_pkg;
    localparam int MODE_W  = 2;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_SLEEP   = 2'd0,
        ST_STANDBY = 2'd1,
        ST_IDLE    = 2'd2,
        ST_ACTIVE  = 2'd3
    } pstate_e;

    localparam logic [MODE_W-1:0] MF_STANDBY = 2'b00;
    localparam logic [MODE_W-1:0] MF_IDLE    = 2'b01;
endpackage

// File: rtl/pmfe_mode_fsm.sv
module pmfe_mode_fsm
    import pmfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic [MODE_W-1:0] mode_fld,
    output pstate_e           state_q,
    output pstate_e           state_d,
    output logic              reload_q
);
    // Mode field decode: 1x is active regardless of low bit.
    function automatic pstate_e decode_mode(input logic [MODE_W-1:0] f);
        if (f[MODE_W-1])          return ST_ACTIVE;
        else if (f == MF_IDLE)    return ST_IDLE;
        else                      return ST_STANDBY;
    endfunction

    always_comb begin
        state_d = state_q;
        if (!pwr_en) begin
            state_d = ST_SLEEP;                  // T_POWER_DOWN
        end else begin
            unique case (state_q)
                ST_SLEEP:   state_d = ST_STANDBY; // T_WAKE
                ST_STANDBY,
                ST_IDLE,
                ST_ACTIVE:  state_d = decode_mode(mode_fld); // T_SELECT
                default:    state_d = ST_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SLEEP;
            reload_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            reload_q <= (state_q == ST_SLEEP) && pwr_en;
        end
    end

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (state_q == ST_SLEEP));
    // R3
    wake_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && pwr_en) |=> (state_q == ST_STANDBY && reload_q));
    // R3
    reload_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_q |=> !reload_q);
endmodule

// File: rtl/pmfe_fe_drive.sv
module pmfe_fe_drive
    import pmfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pstate_e state_d,
    input  logic    tx_sel,
    input  logic    pa_en,
    input  logic    band_a,
    input  logic    cal_busy,
    output logic    osc_on,
    output logic    ser_on,
    output logic    vco_on,
    output logic    tx_on,
    output logic    rx_on,
    output logic    fe_off,
    output logic    pa_off_a,
    output logic    pa_off_b,
    output logic    band_out,
    output logic    cal_act
);
    logic osc_d, vco_d, tx_d, rx_d, fe_off_d, pa_a_d, pa_b_d, band_d, cal_d;

    always_comb begin
        osc_d    = 1'b0;
        vco_d    = 1'b0;
        tx_d     = 1'b0;
        rx_d     = 1'b0;
        fe_off_d = 1'b1;
        pa_a_d   = 1'b1;
        pa_b_d   = 1'b1;
        band_d   = 1'b0;
        cal_d    = 1'b0;
        unique case (state_d)
            ST_SLEEP: begin
            end
            ST_STANDBY: begin
                osc_d  = 1'b1;
                band_d = band_a;
            end
            ST_IDLE: begin
                osc_d  = 1'b1;
                vco_d  = 1'b1;
                band_d = band_a;
            end
            ST_ACTIVE: begin
                osc_d  = 1'b1;
                vco_d  = 1'b1;
                band_d = band_a;
                tx_d   = tx_sel;
                rx_d   = !tx_sel;
                cal_d  = !tx_sel && cal_busy;
                fe_off_d = cal_d;
                if (tx_sel && pa_en && !cal_d) begin
                    pa_a_d = !band_a;
                    pa_b_d = band_a;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_on   <= 1'b0;
            ser_on   <= 1'b0;
            vco_on   <= 1'b0;
            tx_on    <= 1'b0;
            rx_on    <= 1'b0;
            fe_off   <= 1'b1;
            pa_off_a <= 1'b1;
            pa_off_b <= 1'b1;
            band_out <= 1'b0;
            cal_act  <= 1'b0;
        end else begin
            osc_on   <= osc_d;
            ser_on   <= osc_d;
            vco_on   <= vco_d;
            tx_on    <= tx_d;
            rx_on    <= rx_d;
            fe_off   <= fe_off_d;
            pa_off_a <= pa_a_d;
            pa_off_b <= pa_b_d;
            band_out <= band_d;
            cal_act  <= cal_d;
        end
    end

    // R6
    pa_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_off_a |-> pa_off_b);
    // R6
    pa_needs_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pa_off_a || !pa_off_b) |-> (tx_on && !fe_off));
    // R5
    txrx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_on && rx_on));
    // R4
    vco_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vco_on |-> (osc_on && ser_on));
    // R9
    cal_holds_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_act |-> (fe_off && rx_on && !tx_on));
endmodule

// File: rtl/pmfe_ctrl.sv
module pmfe_ctrl
    import pmfe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_en,
    input  logic [MODE_W-1:0]  mode_fld,
    input  logic               tx_sel,
    input  logic               pa_en,
    input  logic               band_a,
    input  logic               cal_busy,
    output logic [STATE_W-1:0] pwr_state,
    output logic               osc_on,
    output logic               ser_on,
    output logic               vco_on,
    output logic               tx_on,
    output logic               rx_on,
    output logic               fe_off,
    output logic               pa_off_a,
    output logic               pa_off_b,
    output logic               band_out,
    output logic               cal_act,
    output logic               reload_pulse
);
    pstate_e st_q, st_d;

    pmfe_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en   (pwr_en),
        .mode_fld (mode_fld),
        .state_q  (st_q),
        .state_d  (st_d),
        .reload_q (reload_pulse)
    );

    pmfe_fe_drive u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_d  (st_d),
        .tx_sel   (tx_sel),
        .pa_en    (pa_en),
        .band_a   (band_a),
        .cal_busy (cal_busy),
        .osc_on   (osc_on),
        .ser_on   (ser_on),
        .vco_on   (vco_on),
        .tx_on    (tx_on),
        .rx_on    (rx_on),
        .fe_off   (fe_off),
        .pa_off_a (pa_off_a),
        .pa_off_b (pa_off_b),
        .band_out (band_out),
        .cal_act  (cal_act)
    );

    assign pwr_state = st_q;

    // R8
    fe_on_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_off |-> (pwr_state == 2'd3 && !cal_act));
    // R7
    band_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0) |-> (!band_out && !osc_on));
endmodule

// File: tb/pmfe_ctrl_tb_top.sv
module pmfe_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0;
    logic [1:0] mode_fld = 2'b00;
    logic tx_sel = 1'b0, pa_en = 1'b0, band_a = 1'b0, cal_busy = 1'b0;
    logic [1:0] pwr_state;
    logic osc_on, ser_on, vco_on, tx_on, rx_on, fe_off, pa_off_a, pa_off_b;
    logic band_out, cal_act, reload_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pmfe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .mode_fld(mode_fld),
        .tx_sel(tx_sel), .pa_en(pa_en), .band_a(band_a), .cal_busy(cal_busy),
        .pwr_state(pwr_state), .osc_on(osc_on), .ser_on(ser_on), .vco_on(vco_on),
        .tx_on(tx_on), .rx_on(rx_on), .fe_off(fe_off), .pa_off_a(pa_off_a),
        .pa_off_b(pa_off_b), .band_out(band_out), .cal_act(cal_act),
        .reload_pulse(reload_pulse)
    );

    typedef struct {
        logic [14:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    logic [1:0] m_state = 2'd0;

    function automatic logic [14:0] observed();
        return {pwr_state, osc_on, ser_on, vco_on, tx_on, rx_on, fe_off,
                pa_off_a, pa_off_b, band_out, cal_act, reload_pulse, 2'b00};
    endfunction

    // Reference model built from the requirement list.
    task automatic drive(input logic pe, input logic [1:0] mf, input logic tr,
                         input logic pa, input logic ba, input logic cb,
                         input string tag);
        logic [1:0] ns;
        logic rel, osc, vco, tx, rx, fo, pa_a, pa_b, bo, ca;
        item_t it;
        pwr_en = pe; mode_fld = mf; tx_sel = tr; pa_en = pa; band_a = ba; cal_busy = cb;
        rel = 1'b0;
        if (!pe)                 ns = 2'd0;
        else if (m_state == 2'd0) begin ns = 2'd1; rel = 1'b1; end
        else if (mf[1])          ns = 2'd3;
        else if (mf == 2'b01)    ns = 2'd2;
        else                     ns = 2'd1;
        osc = (ns != 2'd0);
        vco = (ns >= 2'd2);
        tx  = (ns == 2'd3) && tr;
        rx  = (ns == 2'd3) && !tr;
        ca  = rx && cb;
        fo  = !((ns == 2'd3) && !ca);
        pa_a = !(tx && pa && ba);
        pa_b = !(tx && pa && !ba);
        bo  = osc ? ba : 1'b0;
        it.exp = {ns, osc, osc, vco, tx, rx, fo, pa_a, pa_b, bo, ca, rel, 2'b00};
        it.tag = tag;
        sb_q.push_back(it);
        m_state = ns;
        @(negedge clk);
    endtask

    // Monitor: compare just after the edge that registers the driven inputs.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (observed() !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%b expected=%b", it.tag, observed(), it.exp);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (observed() !== {2'd0, 5'b00000, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 2'b00}) begin
            bad++;
            $display("FAIL R1 actual=%b expected=%b", observed(),
                     {2'd0, 5'b00000, 1'b1, 2'b11, 3'b000, 2'b00});
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R2: sleep held with active mode field and PA requested
        drive(1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, "R2_held_sleep");
        // R3: wake passes through standby with reload, ignoring field
        drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R3_wake_standby");
        drive(1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R4_active_11_R5_rx");
        drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, "R4_standby_R7_band");
        drive(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, "R4_idle_R6_no_pa");
        drive(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, "R9_cal_in_idle_ignored");
        drive(1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0, "R5_tx_R6_pa_disabled");
        drive(1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, "R6_pa_band_a");
        drive(1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, "R6_pa_band_b_R7");
        drive(1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, "R9_cal_in_tx_ignored");
        drive(1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "R8_rx_front_end_on");
        drive(1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "R9_cal_rx_R8_fe_off");
        drive(1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, "R10_cal_release");
        drive(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, "R9_cal_in_standby");
        drive(1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, "R10_back_to_active");
        drive(1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, "R2_power_down_R7");
        drive(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R3_rewake");
        drive(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R3_follow_idle");
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule